// File: doc/BRIEF.md
# Serial Buffer Interrupt Flags

This block holds the two interrupt flags of a serial port's data buffers and turns them into interrupt requests. The transmit flag records that the word in the transmit buffer has moved on into the shift register, so the next word may be written. The receive flag records that the receive FIFO has filled up to a programmable number of entries. In standard mode that number is one entry.

Software reads both flags as one byte and clears them by writing zeros. Writing ones leaves the flags alone, so a read-modify-write cannot wipe out an event that arrives in between. Each flag has an enable bit. A request output stays high while its flag and its enable are both 1.

The FIFO storage, the shift registers and the interrupt controller are outside this block. The receive FIFO level comes in as a plain count.

Top module: `sbuf_irq_flags`

## Requirements
- R1: While reset is asserted and right after it, both flags read 0 and both request outputs are 0.
- R2: The flag byte places the transmit flag at bit 1 and the receive flag at bit 0. Bits 7 to 2 always read 0.
- R3: A cycle with `tx_xfer` high sets the transmit flag, and the flag is visible after that clock edge.
- R4: With `std_mode` low, the receive threshold is `thr_code` + 1 entries (code 0..3 gives 1..4). The receive flag sets at the edge where `rx_level` first becomes greater than or equal to the threshold.
- R5: With `std_mode` high, the threshold is 1 entry whatever `thr_code` holds.
- R6: While `rx_level` stays at or above the threshold, the receive flag does not set again after a clear. It sets again only after the level has dropped below the threshold and come back up.
- R7: A write (`reg_we` high) clears each flag whose bit in `reg_wdata` is 0. A bit written as 1 leaves its flag unchanged.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: `tx_irq` equals the transmit flag AND `tx_irq_en`, and `rx_irq` equals the receive flag AND `rx_irq_en`. A request therefore stays high until its flag is cleared or its enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_xfer | input | 1 | Strobe: the transmit buffer word moved into the shift register |
| rx_level | input | LVL_W | Number of entries currently in the receive FIFO |
| thr_code | input | 2 | Receive threshold code; the threshold is code + 1 entries |
| std_mode | input | 1 | Standard mode; forces the threshold to 1 |
| tx_irq_en | input | 1 | Enable for the transmit request |
| rx_irq_en | input | 1 | Enable for the receive request |
| reg_we | input | 1 | Write strobe for the flag register |
| reg_wdata | input | 8 | Write data; a 0 clears the flag at that bit |
| reg_rdata | output | 8 | Flag register read value |
| tx_irq | output | 1 | Transmit buffer empty request |
| rx_irq | output | 1 | Receive threshold request |

## Verification
The bench builds the block with its default `LVL_W` of 3, so `rx_level` can reach 7. That covers every threshold from 1 to 4 and also lets the level sit above the threshold or jump past it. At this width the bench exercises the reach-or-pass edge, the no-retrigger behaviour while the level stays high, and rearming after the level drops below the threshold. The standard-mode override is run with the largest code, so a wrong threshold shows up as a missing set.

// File: rtl/sbuf_irq_flags.sv
module sbuf_irq_flags #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_xfer,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [1:0]       thr_code,
  input  logic             std_mode,
  input  logic             tx_irq_en,
  input  logic             rx_irq_en,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             tx_irq,
  output logic             rx_irq
);
  localparam int TX_BIT = 1;
  localparam int RX_BIT = 0;

  logic             tx_flag, rx_flag, rx_above_q;
  logic [LVL_W-1:0] rx_thr;
  logic             rx_above, rx_set, tx_clr, rx_clr;

  assign rx_thr   = std_mode ? LVL_W'(1) : LVL_W'(thr_code) + LVL_W'(1);
  assign rx_above = rx_level >= rx_thr;
  assign rx_set   = rx_above & ~rx_above_q;
  assign tx_clr   = reg_we & ~reg_wdata[TX_BIT];
  assign rx_clr   = reg_we & ~reg_wdata[RX_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flag    <= 1'b0;
      rx_flag    <= 1'b0;
      rx_above_q <= 1'b0;
    end else begin
      tx_flag    <= (tx_flag & ~tx_clr) | tx_xfer;
      rx_flag    <= (rx_flag & ~rx_clr) | rx_set;
      rx_above_q <= rx_above;
    end
  end

  assign reg_rdata = {6'b0, tx_flag, rx_flag};
  assign tx_irq    = tx_flag & tx_irq_en;
  assign rx_irq    = rx_flag & rx_irq_en;
endmodule

// File: rtl/sbuf_irq_flags_chk.sv
module sbuf_irq_flags_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_xfer,
  input logic [LVL_W-1:0] rx_level,
  input logic [1:0]       thr_code,
  input logic             std_mode,
  input logic             tx_irq_en,
  input logic             rx_irq_en,
  input logic             reg_we,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             tx_irq,
  input logic             rx_irq
);
  int unsigned lim;
  assign lim = std_mode ? 1 : int'(thr_code) + 1;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:2] == 6'b0);

  // R3
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_xfer |=> reg_rdata[1]);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_wdata[1] && !tx_xfer) |=> !reg_rdata[1]);

  // R7
  write_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[1] && !tx_xfer) |=> reg_rdata[1] == $past(reg_rdata[1]));

  // R4
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> int'($past(rx_level)) >= $past(lim));

  // R9
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq == (reg_rdata[1] && tx_irq_en));

  // R9
  rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (reg_rdata[0] && rx_irq_en));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (reg_rdata == 8'h00 && !tx_irq && !rx_irq));
endmodule

bind sbuf_irq_flags sbuf_irq_flags_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_xfer(tx_xfer), .rx_level(rx_level),
  .thr_code(thr_code), .std_mode(std_mode), .tx_irq_en(tx_irq_en),
  .rx_irq_en(rx_irq_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/sim_sbuf_irq_flags.sv
module sim_sbuf_irq_flags;
  localparam int LVL_W = 3;

  typedef struct {
    logic [7:0] rd;
    logic       ti;
    logic       ri;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tx_xfer = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [1:0]       thr_code = 2'd0;
  logic             std_mode = 1'b0;
  logic             tx_irq_en = 1'b0;
  logic             rx_irq_en = 1'b0;
  logic             reg_we = 1'b0;
  logic [7:0]       reg_wdata = 8'h00;
  logic [7:0]       reg_rdata;
  logic             tx_irq, rx_irq;

  int   checks = 0;
  int   fails = 0;
  exp_t q[$];
  bit   m_tx = 0, m_rx = 0, m_above = 0;

  always #2 clk = ~clk;

  sbuf_irq_flags #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_xfer(tx_xfer), .rx_level(rx_level),
    .thr_code(thr_code), .std_mode(std_mode), .tx_irq_en(tx_irq_en),
    .rx_irq_en(rx_irq_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (reg_rdata !== e.rd || tx_irq !== e.ti || rx_irq !== e.ri) begin
        fails++;
        $display("FAIL %s: rdata=%h tx_irq=%b rx_irq=%b expected rdata=%h tx_irq=%b rx_irq=%b",
                 e.tag, reg_rdata, tx_irq, rx_irq, e.rd, e.ti, e.ri);
      end
    end
  end

  task automatic step(input bit tx, input int lvl, input int code, input bit std,
                      input bit te, input bit re, input bit we, input logic [7:0] wd,
                      input string tag);
    int   thr;
    bit   above;
    exp_t e;
    @(negedge clk);
    #1;
    tx_xfer = tx; rx_level = LVL_W'(lvl); thr_code = 2'(code); std_mode = std;
    tx_irq_en = te; rx_irq_en = re; reg_we = we; reg_wdata = wd;
    thr   = std ? 1 : code + 1;
    above = lvl >= thr;
    m_tx  = (m_tx && !(we && !wd[1])) || tx;
    m_rx  = (m_rx && !(we && !wd[0])) || (above && !m_above);
    m_above = above;
    @(posedge clk);
    e.rd = {6'b0, m_tx, m_rx};
    e.ti = m_tx && te;
    e.ri = m_rx && re;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #7;
    checks++;
    if (reg_rdata !== 8'h00 || tx_irq !== 1'b0 || rx_irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: rdata=%h irqs=%b%b expected 00 00", reg_rdata, tx_irq, rx_irq);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 1, 1, 0, 8'h00, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 8'h00, "R3 R2");
    step(0, 0, 0, 0, 0, 0, 1, 8'hFF, "R7 write ones");
    step(0, 0, 0, 0, 1, 0, 0, 8'h00, "R9 tx request");
    step(0, 0, 0, 0, 1, 0, 0, 8'h00, "R9 held");
    step(0, 0, 0, 0, 1, 0, 1, 8'h00, "R7 clear");
    step(1, 0, 0, 0, 1, 0, 1, 8'h00, "R8 tx set wins");
    step(0, 0, 0, 0, 0, 0, 1, 8'h01, "R7 clear tx only");
    step(0, 1, 2, 0, 0, 1, 0, 8'h00, "R4 below threshold 3");
    step(0, 2, 2, 0, 0, 1, 0, 8'h00, "R4 below threshold 3");
    step(0, 3, 2, 0, 0, 1, 0, 8'h00, "R4 reach threshold 3");
    step(0, 4, 2, 0, 0, 1, 1, 8'h02, "R6 clear above");
    step(0, 5, 2, 0, 0, 1, 0, 8'h00, "R6 no retrigger");
    step(0, 2, 2, 0, 0, 1, 0, 8'h00, "R6 drop");
    step(1, 6, 2, 0, 1, 1, 0, 8'h00, "R6 rearm pass");
    step(0, 0, 3, 0, 0, 0, 1, 8'h00, "R7 clear both");
    step(0, 3, 3, 0, 0, 0, 0, 8'h00, "R4 below threshold 4");
    step(0, 4, 3, 0, 0, 1, 0, 8'h00, "R4 reach threshold 4");
    step(0, 0, 0, 0, 0, 1, 1, 8'h00, "R7 clear rx");
    step(0, 1, 0, 0, 0, 1, 0, 8'h00, "R4 threshold 1");
    step(0, 0, 3, 1, 0, 0, 1, 8'h00, "R7 clear");
    step(0, 1, 3, 1, 0, 1, 0, 8'h00, "R5 std mode");
    step(0, 0, 1, 0, 0, 0, 1, 8'h02, "R7 clear rx");
    step(0, 2, 1, 0, 0, 1, 1, 8'h00, "R8 rx set wins");
    step(0, 2, 1, 0, 0, 1, 1, 8'hFF, "R7 ones keep");
    step(0, 0, 0, 0, 0, 0, 0, 8'h00, "R2 idle");
    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule